// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Transmitter

This block turns one parallel character into an asynchronous frame on a single output line. Between frames the line rests high (mark). A frame is one low start bit, then the character bits least significant first, then a high stop interval. Two framings are available. The first sends every character bit with no parity. The second sends all but the top character bit and puts a computed parity bit in the last data slot. Parity can be even or odd, and the stop interval lasts one, one and a half or two bit periods.

Timing comes from `tick_2x`, a single-cycle enable pulse at twice the bit rate. Each bit lasts two ticks, which lets the block make the half-bit stop length. A character enters through a valid/ready handshake. The framing, parity and stop selections are captured together with the character, so the caller may change them while a frame is on the line. The line is a logic-level signal; level shifting and inversion belong to other blocks.

Top module: `async_char_tx`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `line_out` is 1 and `in_ready` is 1.
- R2: The clock edge where `in_valid` and `in_ready` are both high accepts the character. Right after that edge `busy` is 1 and `line_out` is 0, and this start level lasts for two `tick_2x` pulses.
- R3: After the start bit come data slots 1 to 8, least significant first. Each slot lasts two ticks.
- R4: When `full_width` is 0, slots 1 to 7 carry `in_data[6:0]` and slot 8 carries the parity bit. `in_data[7]` is ignored.
- R5: When `par_odd` is 0, the parity bit makes the number of ones over `in_data[6:0]` plus parity even. When `par_odd` is 1, it makes that count odd. Example: 7'b1001101 with even parity gives a parity bit of 0.
- R6: When `full_width` is 1, slots 1 to 8 carry `in_data[7:0]` and no parity bit is sent.
- R7: The stop interval is high. Its length in ticks depends on `stop_sel`: 0 gives 2 ticks, 1 gives 3 ticks, and 2 or 3 gives 4 ticks. The whole frame therefore lasts 20, 21 or 22 ticks.
- R8: While `busy` is 1, `in_ready` is 0. A character offered during that time is not taken and does not alter the frame on the line.
- R9: Changes to `in_data`, `full_width`, `par_odd` and `stop_sel` after acceptance have no effect on the frame in progress.
- R10: The clock edge that takes the last stop tick also drops `busy` and raises `in_ready`, with `line_out` at 1. A character already waiting is accepted on the next edge.
- R11: Without a `tick_2x` pulse the frame does not advance: `line_out` and `busy` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_2x | input | 1 | Enable pulse at twice the bit rate |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The block can take a character |
| in_data | input | CHAR_W | Character to send |
| full_width | input | 1 | 1: all CHAR_W bits with no parity; 0: CHAR_W-1 bits plus parity |
| par_odd | input | 1 | 0: even parity; 1: odd parity |
| stop_sel | input | 2 | Stop length: 0 one bit, 1 one and a half bits, 2 or 3 two bits |
| line_out | output | 1 | Serial line, 1 = mark |
| busy | output | 1 | A frame is in progress |

## Verification
The assertions assume that `tick_2x`, `in_valid` and the configuration inputs are synchronous to `clk`, and that reset is applied before the first frame. They do not assume any spacing between ticks. The stimulus changes every input at the falling clock edge and produces ticks from a free-running divide-by-three counter that the bench can gate off. Those gaps in the ticks test the hold behaviour without leaving the assumed input range. Stop length code 3 and characters whose top bit conflicts with the parity bit are both in the stimulus.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2,
    STOP_TWO_ALT  = 2'd3
  } stop_len_e;

  // Stop interval length counted in half-bit ticks
  function automatic logic [2:0] stop_halves(input stop_len_e sel);
    case (sel)
      STOP_ONE:      return 3'd2;
      STOP_ONE_HALF: return 3'd3;
      default:       return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/tx_frame_builder.sv
module tx_frame_builder #(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] data,
  input  logic              full_width,
  input  logic              odd_parity,
  output logic [CHAR_W+1:0] frame
);

  // Parity over the low CHAR_W-1 bits; odd mode flips the even result
  function automatic logic char_parity(input logic [CHAR_W-2:0] low,
                                       input logic odd);
    return (^low) ^ odd;
  endfunction

  logic [CHAR_W-1:0] payload;

  always_comb begin
    if (full_width)
      payload = data;
    else
      payload = {char_parity(data[CHAR_W-2:0], odd_parity), data[CHAR_W-2:0]};
    // slot 0 start (space), slots 1..CHAR_W payload, last slot stop (mark)
    frame = {1'b1, payload, 1'b0};
  end

endmodule

// File: rtl/tx_half_counter.sv
module tx_half_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             last
);

  assign last = run && tick && (count == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clear || last)
      count <= '0;
    else if (run && tick)
      count <= count + 1'b1;
  end

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_2x,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              full_width,
  input  logic              par_odd,
  input  logic [1:0]        stop_sel,
  output logic              line_out,
  output logic              busy
);
  import async_tx_pkg::*;

  localparam int FRAME_W    = CHAR_W + 2;
  localparam int BODY_HALF  = 2 * (CHAR_W + 1);
  localparam int MAX_HALVES = BODY_HALF + 4;
  localparam int CNT_W      = $clog2(MAX_HALVES + 1);
  localparam int SLOT_W     = $clog2(FRAME_W);

  // named internal events, visible to the bound checker
  logic                accept;
  logic                frame_done;
  logic [FRAME_W-1:0]  frame_q;
  logic [SLOT_W-1:0]   slot_idx;

  logic [FRAME_W-1:0]  frame_built;
  stop_len_e           stop_q;
  logic [CNT_W-1:0]    half_count;
  logic [CNT_W-1:0]    half_limit;
  logic [CNT_W-1:0]    slot_raw;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  tx_frame_builder #(.CHAR_W(CHAR_W)) u_build (
    .data       (in_data),
    .full_width (full_width),
    .odd_parity (par_odd),
    .frame      (frame_built)
  );

  assign half_limit = CNT_W'(BODY_HALF) + CNT_W'(stop_halves(stop_q));

  tx_half_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .run   (busy),
    .tick  (tick_2x),
    .limit (half_limit),
    .count (half_count),
    .last  (frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '1;
      stop_q  <= STOP_ONE;
    end else if (accept) begin
      busy    <= 1'b1;
      frame_q <= frame_built;
      stop_q  <= stop_len_e'(stop_sel);
    end else if (frame_done) begin
      busy    <= 1'b0;
    end
  end

  // two ticks per slot; stop ticks past the last slot stay on the mark slot
  always_comb begin
    slot_raw = half_count >> 1;
    if (slot_raw >= CNT_W'(FRAME_W - 1))
      slot_idx = SLOT_W'(FRAME_W - 1);
    else
      slot_idx = SLOT_W'(slot_raw);
  end

  assign line_out = busy ? frame_q[slot_idx] : 1'b1;

endmodule

// File: rtl/async_char_tx_chk.sv
module async_char_tx_chk #(
  parameter int CHAR_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick_2x,
  input logic                      in_ready,
  input logic                      line_out,
  input logic                      busy,
  input logic                      accept,
  input logic                      frame_done,
  input logic [$clog2(CHAR_W+2)-1:0] slot_idx,
  input logic [CHAR_W+1:0]         frame_q
);
  localparam int FRAME_W = CHAR_W + 2;
  localparam int SLOT_W  = $clog2(FRAME_W);

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out && in_ready);

  // R2
  start_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !line_out);

  // R7
  stop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && slot_idx == SLOT_W'(FRAME_W - 1) |-> line_out);

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !frame_done |=> $stable(frame_q) && busy);

  // R10
  ready_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy && in_ready && line_out);

  // R11
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> tick_2x);

  // R11
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick_2x |=> busy && $stable(slot_idx) && $stable(line_out));

endmodule

bind async_char_tx async_char_tx_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_2x    (tick_2x),
  .in_ready   (in_ready),
  .line_out   (line_out),
  .busy       (busy),
  .accept     (accept),
  .frame_done (frame_done),
  .slot_idx   (slot_idx),
  .frame_q    (frame_q)
);

// File: tb/async_char_tx_test.sv
module async_char_tx_test;

  typedef struct packed {
    logic [7:0] d;
    logic       f;
    logic       o;
    logic [1:0] s;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'h4D, 1'b0, 1'b0, 2'd0},
    '{8'h4D, 1'b0, 1'b1, 2'd1},
    '{8'hA5, 1'b1, 1'b0, 2'd2},
    '{8'hFF, 1'b0, 1'b0, 2'd3},
    '{8'h00, 1'b0, 1'b1, 2'd0},
    '{8'h80, 1'b0, 1'b0, 2'd1},
    '{8'h01, 1'b1, 1'b1, 2'd0},
    '{8'h3C, 1'b1, 1'b0, 2'd3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_2x = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       full_width = 1'b0;
  logic       par_odd = 1'b0;
  logic [1:0] stop_sel = 2'd0;
  logic       line_out;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tcnt = 0;
  logic tick_en = 1'b1;

  async_char_tx #(.CHAR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick_2x(tick_2x), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .full_width(full_width),
    .par_odd(par_odd), .stop_sel(stop_sel), .line_out(line_out), .busy(busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tcnt    <= (tcnt == 2) ? 0 : tcnt + 1;
    tick_2x <= (tcnt == 2) && tick_en;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected line level for half-bit number h of the frame
  function automatic logic exp_half(input vec_t v, input int h);
    int b;
    logic [7:0] p;
    b = h / 2;
    if (v.f) p = v.d;
    else     p = {(v.d[0]+v.d[1]+v.d[2]+v.d[3]+v.d[4]+v.d[5]+v.d[6]) % 2 == 1 ? ~v.o : v.o,
                  v.d[6:0]};
    if (b == 0) return 1'b0;
    if (b <= 8) return p[b-1];
    return 1'b1;
  endfunction

  function automatic int exp_len(input vec_t v);
    return 18 + ((v.s == 2'd0) ? 2 : (v.s == 2'd1) ? 3 : 4);
  endfunction

  function automatic string slot_tag(input vec_t v, input int h);
    int b;
    b = h / 2;
    if (b == 0) return "R2 start";
    if (b == 8 && !v.f) return "R5 parity";
    if (b <= 8) return v.f ? "R6 data" : "R3/R4 data";
    return "R7 stop";
  endfunction

  task automatic apply(input vec_t v);
    in_data = v.d; full_width = v.f; par_odd = v.o; stop_sel = v.s;
  endtask

  // offer v at a falling edge and return at the first falling edge with busy
  task automatic send(input vec_t v, input bit keep);
    int g;
    @(negedge clk);
    apply(v);
    in_valid = 1'b1;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!busy && g < 100);
    chk(busy && !line_out, "R2 accept", {busy, line_out}, 2'b10);
    if (!keep) in_valid = 1'b0;
  endtask

  task automatic capture(input vec_t v, input bit scramble, input int pause_at);
    int n;
    int g;
    int pa;
    logic held_line;
    n = 0; g = 0; pa = pause_at;
    while (busy && g < 1000) begin
      if (pa >= 0 && n == pa && !tick_2x) begin
        tick_en = 1'b0;
        held_line = line_out;
        repeat (12) @(negedge clk);
        chk(busy && line_out == held_line, "R11 hold",
            {busy, line_out}, {1'b1, held_line});
        tick_en = 1'b1;
        pa = -1;
      end
      if (tick_2x) begin
        chk(line_out === exp_half(v, n), slot_tag(v, n), line_out, exp_half(v, n));
        n++;
      end
      if (scramble) begin
        in_data = ~in_data; full_width = ~full_width;
        par_odd = ~par_odd; stop_sel = stop_sel + 2'd1;
      end
      @(negedge clk);
      g++;
    end
    chk(n == exp_len(v), "R7 length", n, exp_len(v));
    chk(line_out && in_ready, "R10 end idle", {line_out, in_ready}, 2'b11);
  endtask

  initial begin
    vec_t a;
    vec_t b;
    repeat (3) @(negedge clk);
    chk(line_out && in_ready && !busy, "R1 reset", {line_out, in_ready, busy}, 3'b110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(line_out && in_ready && !busy, "R1 idle", {line_out, in_ready, busy}, 3'b110);

    for (int i = 0; i < NVEC; i++) begin
      send(VECS[i], 1'b0);
      capture(VECS[i], 1'b0, -1);
      repeat (i % 3) @(negedge clk);
    end

    // R9: inputs toggle every cycle during the frame
    send(VECS[1], 1'b0);
    capture(VECS[1], 1'b1, -1);

    // R11: tick pulses stop in mid character
    send(VECS[2], 1'b0);
    capture(VECS[2], 1'b0, 7);

    // R8 and R10: next character waits while busy, accepted on the edge after the end
    a = VECS[3];
    b = VECS[6];
    send(a, 1'b1);
    apply(b);
    chk(!in_ready, "R8 ready low", in_ready, 1'b0);
    capture(a, 1'b0, -1);
    @(negedge clk);
    chk(busy && !line_out, "R10 back to back", {busy, line_out}, 2'b10);
    in_valid = 1'b0;
    capture(b, 1'b0, -1);

    // R1: reset in mid frame returns the line to mark
    send(VECS[0], 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(line_out && in_ready && !busy, "R1 mid reset", {line_out, in_ready, busy}, 3'b110);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule